// File: doc/BRIEF.md
# FFT Output Reorder Buffer (Bit-Reversed to Natural Order)

A pipelined decimation-in-frequency FFT emits the bins of each frame with their index bit-reversed. This block sits after such an FFT and puts each frame back into natural bin order, so bin 0 (DC) comes out first and bin N-1 last. N is a power of two, set as `1 << LOG2N`. One complex word enters and one leaves on every clock where the clock enable `ce` is high. Nothing moves on other clocks.

Two storage banks of N words each take turns. Incoming samples are written into one bank at their arrival position. At the same time, the bank filled during the previous frame is read at the bit-reversed position of the same counter. The roles of the banks swap at every frame boundary, so the stream never stalls. The input marker `in_sync` aligns the framing to the upstream FFT once. After that, frames follow one another every N accepted samples. The output marker `out_sync` flags the word that carries bin 0.

The reorder adds one frame of latency. No output appears until a whole frame has been stored.

Top module: `fft_bitrev_reorder`

## Requirements
- R1: Each word is one complex sample, 2*CW bits wide: the real part in the upper CW bits and the imaginary part in the lower CW bits, both in two's complement. The block returns every word bit-for-bit unchanged, only in a new order.
- R2: Enabled samples that arrive before the first `in_sync` since reset are discarded. The sample that arrives with `in_sync` and `ce` both high takes arrival position 0 of the first frame.
- R3: Once framing is locked, frames follow one another every N accepted samples. A later `in_sync` pulse has no effect on the framing or on the data.
- R4: On a clock where `ce` is low, no sample is accepted and `out_data` holds its value. `out_valid` is high only on the cycle right after a clock edge at which `ce` was high.
- R5: Within a frame, the output at bin index k is the sample that arrived at position bitrev(k). Here bitrev reverses the LOG2N-bit index (for N=32, output 1 is the sample from arrival position 16).
- R6: `out_valid` stays low until one whole frame has been stored. The first `out_sync` appears at exactly N enabled clocks after the enabled clock that carried the first `in_sync`. It is registered on the edge that accepts position 0 of the next frame.
- R7: `out_sync` is high only together with `out_valid`, and only on the word that carries bin 0. It therefore recurs once every N valid outputs.
- R8: Every accepted sample is output exactly once, during the frame that follows its own. No sample is overwritten before it has been read.
- R9: A synchronous active-high `rst` clears `out_valid`, `out_sync`, the position counter, the bank select and the frame-stored flag. After reset, a fresh `in_sync` is needed before any sample is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all logic acts on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable; high marks an input sample and advances the block |
| in_sync | input | 1 | High with the first sample of the first frame |
| in_data | input | 2*CW | Input complex word: real part upper, imaginary part lower |
| out_data | output | 2*CW | Reordered complex word, same format as the input |
| out_valid | output | 1 | `out_data` was updated at the last edge |
| out_sync | output | 1 | `out_data` carries bin 0 of a frame |

## Verification
The hardest situation to reach is the frame boundary under stress. This means the cycle where the write side moves to a new bank while the old bank still holds a frame that has not been read, combined with gapped enables, a stray `in_sync`, and a reset in the middle of a frame. The stimulus gets there by streaming whole frames back to back with several enable spacings. It injects a false `in_sync` partway through a frame. It also resets partway through a frame and then re-aligns after a run of samples that must be discarded. A queue model checks every output word for value, order and `out_sync` placement, which makes any overwritten or repeated sample show up as a mismatch.

// File: rtl/reorder_pkg.sv
package reorder_pkg;

    // Which of the two storage banks the write side currently fills.
    typedef enum logic {
        BANK_LO = 1'b0,
        BANK_HI = 1'b1
    } bank_e;

endpackage

// File: rtl/reorder_bitrev.sv
module reorder_bitrev #(
    parameter int W = 5
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    // Mirror the index: bit i of the output is bit W-1-i of the input.
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign dout[i] = din[W-1-i];
    end

endmodule

// File: rtl/reorder_bank.sv
module reorder_bank #(
    parameter int AW = 5,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read is combinational; the top module registers the result.
    assign rdata = mem[raddr];

endmodule

// File: rtl/reorder_ctrl.sv
module reorder_ctrl
    import reorder_pkg::*;
#(
    parameter int LOG2N = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic             in_sync,
    output logic             accept,
    output logic [LOG2N-1:0] wpos,
    output bank_e            wbank,
    output logic             emit,
    output logic             first_bin
);

    localparam logic [LOG2N-1:0] LAST_POS = {LOG2N{1'b1}};

    typedef struct packed {
        logic [LOG2N-1:0] cnt;
        bank_e            wbank;
        logic             filled;
        logic             locked;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // A sample counts if framing is already locked, or if in_sync
        // arrives with it.
        accept    = ce && (st_q.locked || in_sync);
        // Before lock, the sample that brings in_sync takes position 0.
        wpos      = st_q.locked ? st_q.cnt : '0;
        // Output only once the other bank holds a whole frame.
        emit      = accept && st_q.filled;
        first_bin = emit && (wpos == '0);
        if (accept) begin
            st_d.locked = 1'b1;
            st_d.cnt    = wpos + LOG2N'(1);
            if (wpos == LAST_POS) begin
                st_d.wbank  = (st_q.wbank == BANK_LO) ? BANK_HI : BANK_LO;
                st_d.filled = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{cnt: '0, wbank: BANK_LO, filled: 1'b0, locked: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign wbank = st_q.wbank;

endmodule

// File: rtl/fft_bitrev_reorder.sv
module fft_bitrev_reorder
    import reorder_pkg::*;
#(
    parameter int LOG2N = 5,
    parameter int CW    = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce,
    input  logic          in_sync,
    input  logic [2*CW-1:0] in_data,
    output logic [2*CW-1:0] out_data,
    output logic          out_valid,
    output logic          out_sync
);

    localparam int W = 2 * CW;

    typedef struct packed {
        logic [W-1:0] data;
        logic         valid;
        logic         sync;
    } out_st_t;

    logic             accept;
    logic [LOG2N-1:0] wpos;
    logic [LOG2N-1:0] rpos;
    bank_e            wbank;
    logic             emit;
    logic             first_bin;
    logic [1:0]       bank_we;
    logic [W-1:0]     bank_rd [2];
    logic [W-1:0]     rd_word;
    out_st_t          o_d, o_q;

    reorder_ctrl #(.LOG2N(LOG2N)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .in_sync   (in_sync),
        .accept    (accept),
        .wpos      (wpos),
        .wbank     (wbank),
        .emit      (emit),
        .first_bin (first_bin)
    );

    reorder_bitrev #(.W(LOG2N)) u_rev (
        .din  (wpos),
        .dout (rpos)
    );

    // Two banks: the write side fills one at the arrival position, while
    // the other bank is read at the mirrored position.
    for (genvar b = 0; b < 2; b++) begin : g_bank
        assign bank_we[b] = accept && (wbank == ((b == 0) ? BANK_LO : BANK_HI));
        reorder_bank #(.AW(LOG2N), .DW(W)) u_bank (
            .clk   (clk),
            .we    (bank_we[b]),
            .waddr (wpos),
            .wdata (in_data),
            .raddr (rpos),
            .rdata (bank_rd[b])
        );
    end

    assign rd_word = (wbank == BANK_LO) ? bank_rd[1] : bank_rd[0];

    always_comb begin
        o_d       = o_q;
        o_d.valid = emit;
        o_d.sync  = first_bin;
        if (emit) begin
            o_d.data = rd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            o_q <= '{data: '0, valid: 1'b0, sync: 1'b0};
        end else begin
            o_q <= o_d;
        end
    end

    assign out_data  = o_q.data;
    assign out_valid = o_q.valid;
    assign out_sync  = o_q.sync;

endmodule

// File: rtl/reorder_checks.sv
module reorder_checks #(
    parameter int LOG2N = 5,
    parameter int W     = 32
) (
    input logic         clk,
    input logic         rst,
    input logic         ce,
    input logic [W-1:0] out_data,
    input logic         out_valid,
    input logic         out_sync
);

    localparam int N = 1 << LOG2N;

    logic [LOG2N:0] vcnt;
    logic           seen;

    // Number of valid outputs since (and including) the last out_sync.
    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt <= '0;
            seen <= 1'b0;
        end else if (out_valid) begin
            if (out_sync) begin
                vcnt <= (LOG2N+1)'(1);
                seen <= 1'b1;
            end else begin
                vcnt <= vcnt + (LOG2N+1)'(1);
            end
        end
    end

    // R7: out_sync always comes together with out_valid.
    p_sync_marks_valid_r7: assert property (@(posedge clk) disable iff (rst)
        out_sync |-> out_valid);

    // R7: bin 0 is marked once every N valid words.
    p_sync_spacing_r7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && seen) |-> (out_sync == (vcnt == (LOG2N+1)'(N))));

    // R6: the first word ever produced is bin 0.
    p_first_out_is_bin0_r6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !seen) |-> out_sync);

    // R4: output words appear only after an enabled edge.
    p_valid_after_enable_r4: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(ce));

    // R4: data holds across clocks without enable.
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !$past(ce) |-> $stable(out_data));

endmodule

bind fft_bitrev_reorder reorder_checks #(.LOG2N(LOG2N), .W(2*CW)) u_checks (
    .clk       (clk),
    .rst       (rst),
    .ce        (ce),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_sync  (out_sync)
);

// File: tb/tb_fft_bitrev_reorder.sv
`timescale 1ns/1ps
module tb_fft_bitrev_reorder;

    localparam int LOG2N = 5;
    localparam int N     = 1 << LOG2N;
    localparam int CW    = 16;
    localparam int W     = 2 * CW;

    logic         clk = 1'b0;
    logic         rst;
    logic         ce;
    logic         in_sync;
    logic [W-1:0] in_data;
    logic [W-1:0] out_data;
    logic         out_valid;
    logic         out_sync;

    always #2.5 clk = ~clk;

    fft_bitrev_reorder #(.LOG2N(LOG2N), .CW(CW)) dut (
        .clk       (clk),
        .rst       (rst),
        .ce        (ce),
        .in_sync   (in_sync),
        .in_data   (in_data),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_sync  (out_sync)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    // Reference model.
    logic [W-1:0] frame_buf [N];
    int           m_cnt    = 0;
    bit           m_locked = 0;
    logic [W-1:0] exp_q [$];
    bit           exp_first [$];
    int           en_cnt = 0;
    int           sync_idx = 0;
    bit           first_sync_done = 0;

    function automatic int brev(int k);
        int r = 0;
        for (int i = 0; i < LOG2N; i++) begin
            if (k[i]) r |= (1 << (LOG2N - 1 - i));
        end
        return r;
    endfunction

    function automatic logic [W-1:0] mkword(int seed, int i);
        logic [CW-1:0] re;
        logic [CW-1:0] im;
        re = CW'(seed * 977 + i * 131 + 5);
        im = CW'(seed * 313 - i * 59 + 11);
        return {re, im};
    endfunction

    task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // Monitor: samples just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (!rst && !finished) begin
            if (ce) en_cnt++;
            if (!ce) begin
                // R4: no output word after an edge without enable.
                check(!out_valid && !out_sync, "R4 output without enable",
                      W'({out_valid, out_sync}), '0);
            end
            if (out_valid) begin
                if (exp_q.size() == 0) begin
                    // R6 / R2: output before a whole frame was stored.
                    check(1'b0, "R6 output before frame stored", out_data, '0);
                end else begin
                    logic [W-1:0] e;
                    bit           f;
                    e = exp_q.pop_front();
                    f = exp_first.pop_front();
                    check(out_data == e, "R1 R5 R8 reordered word", out_data, e);
                    check(out_sync == f, "R7 bin0 marker", W'(out_sync), W'(f));
                end
                if (out_sync && !first_sync_done) begin
                    first_sync_done = 1;
                    check(en_cnt - sync_idx == N, "R6 first sync latency",
                          W'(en_cnt - sync_idx), W'(N));
                end
            end else if (out_sync) begin
                check(1'b0, "R7 sync without valid", W'(out_sync), '0);
            end
        end
    end

    // Drive one enabled sample, then gap idle clocks.
    task automatic put(bit s, logic [W-1:0] d, int gap);
        @(negedge clk);
        ce      = 1'b1;
        in_sync = s;
        in_data = d;
        if (m_locked || s) begin
            if (!m_locked) sync_idx = en_cnt + 1;
            m_locked = 1;
            frame_buf[m_cnt] = d;
            m_cnt++;
            if (m_cnt == N) begin
                for (int k = 0; k < N; k++) begin
                    exp_q.push_back(frame_buf[brev(k)]);
                    exp_first.push_back(k == 0);
                end
                m_cnt = 0;
            end
        end
        for (int g = 0; g < gap; g++) begin
            @(negedge clk);
            ce      = 1'b0;
            in_sync = 1'b0;
        end
    endtask

    task automatic idle(int n);
        for (int g = 0; g < n; g++) begin
            @(negedge clk);
            ce      = 1'b0;
            in_sync = 1'b0;
        end
    endtask

    task automatic send_frame(int seed, bit with_sync, int gap);
        for (int i = 0; i < N; i++) begin
            put(with_sync && (i == 0), mkword(seed, i), gap);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1; ce = 1'b0; in_sync = 1'b0;
        m_cnt = 0; m_locked = 0; first_sync_done = 0;
        exp_q.delete(); exp_first.delete();
        repeat (3) @(negedge clk);
    endtask

    // R9: outputs are cleared while reset is held.
    task automatic t_reset_state();
        apply_reset();
        check(!out_valid, "R9 out_valid in reset", W'(out_valid), '0);
        check(!out_sync, "R9 out_sync in reset", W'(out_sync), '0);
        check(out_data == '0, "R9 out_data in reset", out_data, '0);
        rst = 1'b0;
    endtask

    // R2 and R6: samples before sync are dropped; first sync after N enables.
    task automatic t_presync_and_stream();
        for (int i = 0; i < 5; i++) put(1'b0, W'(32'hDEAD_0000 + i), 0);
        send_frame(1, 1'b1, 0);
        check(exp_q.size() == N, "R6 one frame queued", W'(exp_q.size()), W'(N));
        send_frame(2, 1'b0, 0);
        send_frame(3, 1'b0, 0);
    endtask

    // R1: extreme two's complement values in both halves.
    task automatic t_extremes();
        for (int i = 0; i < N; i++) begin
            logic [W-1:0] w;
            case (i % 4)
                0: w = {16'h8000, 16'h7FFF};
                1: w = {16'h7FFF, 16'h8000};
                2: w = {16'hFFFF, 16'h0001};
                default: w = mkword(9, i);
            endcase
            put(1'b0, w, 0);
        end
    endtask

    // R4: enable only every second and every third clock.
    task automatic t_gapped();
        send_frame(4, 1'b0, 1);
        send_frame(5, 1'b0, 2);
        send_frame(6, 1'b0, 0);
    endtask

    // R3: a stray sync in mid frame leaves the framing alone.
    task automatic t_stray_sync();
        for (int i = 0; i < N; i++) begin
            put((i == 7) || (i == 20), mkword(7, i), 0);
        end
        send_frame(8, 1'b1, 0);
    endtask

    // R9: reset in mid frame; need a fresh sync afterwards.
    task automatic t_reset_midstream();
        for (int i = 0; i < N / 2; i++) put(1'b0, mkword(10, i), 0);
        apply_reset();
        rst = 1'b0;
        idle(2);
        check(!out_valid, "R9 no output after reset", W'(out_valid), '0);
        for (int i = 0; i < 3; i++) put(1'b0, W'(32'hBAD0_0000 + i), 0);
        send_frame(11, 1'b1, 0);
        send_frame(12, 1'b0, 1);
        send_frame(13, 1'b0, 0);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    endtask

    initial begin
        rst = 1'b1; ce = 1'b0; in_sync = 1'b0; in_data = '0;
        t_reset_state();
        t_presync_and_stream();
        t_extremes();
        t_gapped();
        t_stray_sync();
        t_reset_midstream();
        idle(5);
        // R8: the last frame is still pending; everything else came out once.
        check(exp_q.size() == N, "R8 pending words at end", W'(exp_q.size()), W'(N));
        finished = 1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            summary();
            $finish;
        end
    end

endmodule